// File: doc/BRIEF.md
# Command Outbound Ring Controller

This block is the controller end of a command ring kept in system memory. Software writes 32-bit commands into ring slots, then moves a write pointer forward through a small byte-addressed register window. While its run bit is set, the controller sees that the read pointer is behind the write pointer. It then moves the read pointer on by one slot, fetches that slot with a single-beat memory read, and presents the command word on a valid/ready output port.

The register window holds four 32-bit words, selected by `reg_word` (byte offset divided by four). Byte offsets are 0x0 for the lower ring base, 0x4 for the upper ring base, 0x8 for the write pointer, 0xA for the read pointer, 0xC for control, 0xD for status (reads zero) and 0xE for size. The ring holds 2, 16 or 256 entries. The allowed sizes are fixed at build time and advertised in read-only capability bits.

The engine is a four-state machine:
- `ST_OFF` (stopped) goes to `ST_IDLE` when the run bit is written to 1.
- `ST_IDLE` goes back to `ST_OFF` when the run bit is 0. It goes to `ST_FETCH` when the ring is not empty and no pointer reset is pending, advancing the read pointer on that edge.
- `ST_FETCH` holds the memory request until the read data returns, then goes to `ST_ISSUE`.
- `ST_ISSUE` holds the command until it is accepted, then returns to `ST_IDLE`.

A read-pointer reset requested by software is taken only in `ST_OFF` or `ST_IDLE`.

Top module: `cmd_ring_ctrl`

## Requirements
- R1: After reset, every register word reads 0, except the size byte. The size byte reads the capability flags and the smallest advertised size. `mem_req` and `cmd_valid` are low.
- R2: Bits 6:0 of the lower base word always read 0, and writes to them are ignored. Each memory read address is {upper base, lower base} + 4 × (read pointer).
- R3: Size byte (offset 0xE) bits 6:4 are read-only capability flags: bit 4 means 2 entries, bit 5 means 16 and bit 6 means 256. Bits 1:0 select the size: 00 is 2, 01 is 16 and 10 is 256. A write of an encoding that is not advertised, or a write while the engine is active, leaves the selection unchanged.
- R4: The read pointer (offset 0xA, bits 7:0) and the write pointer (offset 0x8, bits 7:0) wrap modulo the selected size.
- R5: When the read pointer equals the write pointer, no fetch is issued. Otherwise the read pointer advances by one first, and the slot at the new value is fetched, so commands come out in ring order.
- R6: Bit 1 at offset 0xC is the run bit. Reading it returns 1 while the engine is active. After a 0 is written, the in-flight command still completes. The bit reads 0 only once the engine is idle, and no further fetch starts.
- R7: Writing 1 to bit 15 at offset 0xA clears the read pointer to 0, after which bit 15 reads 1. Writing 0 to bit 15 makes it read 0.
- R8: At most one memory read is outstanding. `mem_req` and `mem_addr` stay constant until `mem_rvalid`, and `mem_req` and `cmd_valid` are never high together.
- R9: `cmd_valid` and `cmd_data` stay constant until `cmd_ready` is seen high.
- R10: Only bits 7:0 of the write pointer word are stored. Writes to bits 15:8 of the write pointer are ignored, and those bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 2 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_wstrb | input | 4 | Byte enables for the write |
| reg_rdata | output | 32 | Read data of the selected word |
| mem_req | output | 1 | Memory read request, held until data returns |
| mem_addr | output | 64 | Byte address of the slot being fetched |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| cmd_valid | output | 1 | Command word valid |
| cmd_data | output | 32 | Command word |
| cmd_ready | input | 1 | Command accepted by the consumer |

## Verification
The hardest situation to reach is a stop request that lands while a command is still in flight. The run bit must then keep reading 1, and the pointer state must not move. The bench creates this by holding `cmd_ready` low after queueing one entry. It clears the run bit while `cmd_valid` is waiting, and then advances the write pointer again to show that no new fetch starts. Wrap-around at all three sizes is reached by seeded random batches of up to size−1 entries, on top of random memory latency and random consumer stalls.

// File: rtl/cring_pkg.sv
package cring_pkg;
    localparam int PTR_W  = 8;
    localparam int CMD_W  = 32;
    localparam int ADDR_W = 64;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_FETCH,
        ST_ISSUE
    } eng_state_t;

    localparam logic [1:0] SZ_2   = 2'b00;
    localparam logic [1:0] SZ_16  = 2'b01;
    localparam logic [1:0] SZ_256 = 2'b10;

    function automatic logic [PTR_W-1:0] ring_mask(input logic [1:0] sel);
        case (sel)
            SZ_16:   ring_mask = 8'h0F;
            SZ_256:  ring_mask = 8'hFF;
            default: ring_mask = 8'h01;
        endcase
    endfunction

    function automatic logic size_allowed(input logic [2:0] caps, input logic [1:0] sel);
        case (sel)
            SZ_2:    size_allowed = caps[0];
            SZ_16:   size_allowed = caps[1];
            SZ_256:  size_allowed = caps[2];
            default: size_allowed = 1'b0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] byte_merge(input logic [WORD_W-1:0] old_v,
                                                     input logic [WORD_W-1:0] new_v,
                                                     input logic [3:0]        strb);
        logic [WORD_W-1:0] r;
        r = old_v;
        for (int b = 0; b < 4; b++)
            if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/cring_regs.sv
module cring_regs
    import cring_pkg::*;
#(
    parameter logic [2:0] CAP_MASK = 3'b111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        word,
    input  logic [WORD_W-1:0] wdata,
    input  logic [3:0]        wstrb,
    output logic [WORD_W-1:0] rdata,
    input  logic              eng_active,
    input  logic [PTR_W-1:0]  rp,
    input  logic              clr_ack,
    output logic [ADDR_W-1:0] base,
    output logic [PTR_W-1:0]  wp,
    output logic [PTR_W-1:0]  size_mask,
    output logic              run_req,
    output logic              clr_req
);
    localparam logic [1:0] SEL_RST = CAP_MASK[0] ? SZ_2 : (CAP_MASK[1] ? SZ_16 : SZ_256);
    localparam logic [WORD_W-1:0] BASE_KEEP = 32'hFFFF_FF80;

    logic [WORD_W-1:0] base_lo_q, base_hi_q;
    logic [PTR_W-1:0]  wp_q;
    logic [1:0]        sel_q;
    logic              run_q, pend_q, flag_q;
    logic              sel_ok;

    assign sel_ok = size_allowed(CAP_MASK, wdata[17:16]) && !eng_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            wp_q      <= '0;
            sel_q     <= SEL_RST;
            run_q     <= 1'b0;
            pend_q    <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            if (clr_ack) begin
                pend_q <= 1'b0;
                flag_q <= 1'b1;
            end
            if (wr) begin
                case (word)
                    2'd0: base_lo_q <= byte_merge(base_lo_q, wdata, wstrb) & BASE_KEEP;
                    2'd1: base_hi_q <= byte_merge(base_hi_q, wdata, wstrb);
                    2'd2: begin
                        if (wstrb[0]) wp_q <= wdata[7:0];
                        if (wstrb[3]) begin
                            if (wdata[31]) pend_q <= 1'b1;
                            else begin
                                pend_q <= 1'b0;
                                flag_q <= 1'b0;
                            end
                        end
                    end
                    default: begin
                        if (wstrb[0]) run_q <= wdata[1];
                        if (wstrb[2] && sel_ok) sel_q <= wdata[17:16];
                    end
                endcase
            end
        end
    end

    always_comb begin
        case (word)
            2'd0:    rdata = base_lo_q;
            2'd1:    rdata = base_hi_q;
            2'd2:    rdata = {flag_q, 7'b0, rp, 8'b0, wp_q};
            default: rdata = {8'b0, 1'b0, CAP_MASK, 2'b0, sel_q, 8'h00, 6'b0, eng_active, 1'b0};
        endcase
    end

    assign base      = {base_hi_q, base_lo_q};
    assign wp        = wp_q;
    assign size_mask = ring_mask(sel_q);
    assign run_req   = run_q;
    assign clr_req   = pend_q;

    // R7
    flag_rise_ptr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> rp == '0);

    // R6
    stop_only_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_active) |-> !$past(run_q));

    // R3
    size_frozen_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_q) |-> !$past(eng_active));
endmodule

// File: rtl/cring_engine.sv
module cring_engine
    import cring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic [ADDR_W-1:0] base,
    input  logic [PTR_W-1:0]  wp,
    input  logic [PTR_W-1:0]  size_mask,
    input  logic              clr_req,
    output logic              clr_ack,
    output logic [PTR_W-1:0]  rp,
    output logic              active,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [CMD_W-1:0]  mem_rdata,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_data,
    input  logic              cmd_ready
);
    eng_state_t       state_q, state_d;
    logic [PTR_W-1:0] rp_q, rp_nxt, wp_m;
    logic [CMD_W-1:0] cmd_q;
    logic             has_work;

    assign wp_m     = wp & size_mask;
    assign rp_nxt   = (rp_q + 1'b1) & size_mask;
    assign has_work = (rp_q != wp_m);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (run_req) state_d = ST_IDLE;
            ST_IDLE: begin
                if (!run_req)                  state_d = ST_OFF;
                else if (!clr_req && has_work) state_d = ST_FETCH;
            end
            ST_FETCH: if (mem_rvalid) state_d = ST_ISSUE;
            ST_ISSUE: if (cmd_ready)  state_d = ST_IDLE;
            default:  state_d = ST_OFF;
        endcase
    end

    always_comb begin
        mem_req   = (state_q == ST_FETCH);
        cmd_valid = (state_q == ST_ISSUE);
        active    = (state_q != ST_OFF);
        clr_ack   = clr_req && (state_q == ST_OFF || state_q == ST_IDLE);
        mem_addr  = base + {{(ADDR_W-PTR_W-2){1'b0}}, rp_q, 2'b00};
        cmd_data  = cmd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q  <= '0;
            cmd_q <= '0;
        end else begin
            if (clr_ack)
                rp_q <= '0;
            else if (state_q == ST_IDLE && state_d == ST_FETCH)
                rp_q <= rp_nxt;
            if (state_q == ST_FETCH && mem_rvalid)
                cmd_q <= mem_rdata;
        end
    end

    assign rp = rp_q;

    // R5
    empty_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rp_q == wp_m) |=> !mem_req);

    // R8
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R8
    single_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && cmd_valid));

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
    import cring_pkg::*;
#(
    parameter logic [2:0] CAP_MASK = 3'b111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_word,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [3:0]        reg_wstrb,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [CMD_W-1:0]  mem_rdata,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_data,
    input  logic              cmd_ready
);
    logic              eng_active, clr_ack, clr_req, run_req;
    logic [PTR_W-1:0]  rp, wp, size_mask;
    logic [ADDR_W-1:0] base;

    cring_regs #(.CAP_MASK(CAP_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(reg_wr), .word(reg_word), .wdata(reg_wdata), .wstrb(reg_wstrb), .rdata(reg_rdata),
        .eng_active(eng_active), .rp(rp), .clr_ack(clr_ack),
        .base(base), .wp(wp), .size_mask(size_mask), .run_req(run_req), .clr_req(clr_req)
    );

    cring_engine u_engine (
        .clk(clk), .rst_n(rst_n),
        .run_req(run_req), .base(base), .wp(wp), .size_mask(size_mask),
        .clr_req(clr_req), .clr_ack(clr_ack), .rp(rp), .active(eng_active),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready)
    );
endmodule

// File: tb/cmd_ring_ctrl_bench.sv
`timescale 1ns/1ps
module cmd_ring_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_word = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_wstrb = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        cmd_valid;
    logic [31:0] cmd_data;
    logic        cmd_ready = 1'b0;

    int          n_checks = 0;
    int          n_errors = 0;
    int          n_fetch  = 0;
    bit          hold_ready = 1'b0;
    bit          done = 1'b0;
    logic [31:0] exp_hi = '0;
    logic [31:0] ring_mem [256];
    logic [31:0] exp_q [$];
    logic [7:0]  sw_wp = '0;
    logic [7:0]  cur_mask = 8'h0F;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_ring_ctrl u_cmd_ring_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb),
        .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] sel);
        return (sel == 2'b00) ? 8'h01 : (sel == 2'b01) ? 8'h0F : 8'hFF;
    endfunction

    task automatic reg_write(input logic [1:0] w, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        reg_word = w; reg_wdata = d; reg_wstrb = s; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wstrb = '0;
    endtask

    task automatic reg_read(input logic [1:0] w, output logic [31:0] d);
        @(negedge clk);
        reg_word = w;
        #1 d = reg_rdata;
    endtask

    // memory model: random latency, one request at a time
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                repeat ($urandom_range(0, 3)) @(negedge clk);
                // R2: upper half and the region above the ring index come from the base
                check("R2 fetch address base", {32'h0, mem_addr[63:10]}, {32'h0, exp_hi, 22'd4});
                mem_rdata  = ring_mem[mem_addr[9:2]];
                mem_rvalid = 1'b1;
                n_fetch++;
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end
    end

    // consumer: random stalls, compares against the expected order
    initial begin
        forever begin
            @(negedge clk);
            cmd_ready = hold_ready ? 1'b0 : ($urandom_range(0, 3) != 0);
            #(CLK_PERIOD/4);
            if (cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) check("R5 unexpected command", {32'h0, cmd_data}, 64'hDEAD);
                else check("R5 R9 command order", {32'h0, cmd_data}, {32'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            sw_wp = (sw_wp + 8'd1) & cur_mask;
            ring_mem[sw_wp] = $urandom;
            exp_q.push_back(ring_mem[sw_wp]);
        end
        reg_write(2'd2, {24'h0, sw_wp}, 4'b0001);
    endtask

    task automatic wait_drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check("R5 ring drained", {32'h0, exp_q.size()}, 64'h0);
        repeat (3) @(negedge clk);
    endtask

    task automatic round(input int n);
        logic [31:0] d;
        push(n);
        wait_drain();
        reg_read(2'd2, d);
        check("R4 read pointer after wrap", {56'h0, d[23:16]}, {56'h0, sw_wp});
    endtask

    task automatic stop_engine();
        logic [31:0] d;
        reg_write(2'd3, 32'h0, 4'b0001);
        repeat (4) @(negedge clk);
        reg_read(2'd3, d);
        check("R6 run bit reads 0 when stopped", {63'h0, d[1]}, 64'h0);
    endtask

    task automatic ptr_reset();
        logic [31:0] d;
        reg_write(2'd2, 32'h0, 4'b0001);
        sw_wp = '0;
        reg_write(2'd2, 32'h8000_0000, 4'b1000);
        repeat (2) @(negedge clk);
        reg_read(2'd2, d);
        check("R7 reset flag set and pointer cleared", {48'h0, d[31:16]}, 64'h8000);
        reg_write(2'd2, 32'h0000_0000, 4'b1000);
        repeat (2) @(negedge clk);
        reg_read(2'd2, d);
        check("R7 reset flag cleared", {48'h0, d[31:16]}, 64'h0);
    endtask

    task automatic set_size(input logic [1:0] sel);
        logic [31:0] d;
        reg_write(2'd3, {14'h0, sel, 16'h0}, 4'b0100);
        reg_read(2'd3, d);
        check("R3 size select written", {62'h0, d[17:16]}, {62'h0, sel});
        cur_mask = mask_of(sel);
    endtask

    initial begin
        logic [31:0] d;
        int          f0;
        void'($urandom(32'd20240607));
        for (int i = 0; i < 256; i++) ring_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, d); check("R1 lower base reset", {32'h0, d}, 64'h0);
        reg_read(2'd1, d); check("R1 upper base reset", {32'h0, d}, 64'h0);
        reg_read(2'd2, d); check("R1 pointers reset", {32'h0, d}, 64'h0);
        reg_read(2'd3, d); check("R1 R3 size and control reset", {32'h0, d}, 64'h0070_0000);
        check("R1 no request after reset", {62'h0, mem_req, cmd_valid}, 64'h0);

        // R2 low base bits dropped
        reg_write(2'd0, 32'h0000_10FF, 4'b1111);
        reg_read(2'd0, d); check("R2 low base bits read 0", {32'h0, d}, 64'h1080);
        reg_write(2'd0, 32'h0000_1000, 4'b1111);
        reg_write(2'd1, 32'h0, 4'b1111);

        // R3 size select and illegal encoding
        set_size(2'b01);
        reg_write(2'd3, 32'h0003_0000, 4'b0100);
        reg_read(2'd3, d); check("R3 illegal encoding ignored", {62'h0, d[17:16]}, 64'h1);

        // R6 run bit read-back, R5 empty ring stays quiet
        reg_write(2'd3, 32'h2, 4'b0001);
        repeat (2) @(negedge clk);
        reg_read(2'd3, d); check("R6 run bit reads 1", {63'h0, d[1]}, 64'h1);
        repeat (20) @(negedge clk);
        check("R5 no fetch while empty", {32'h0, n_fetch}, 64'h0);

        // 16-entry ring: full batch plus random batches
        round(15);
        for (int r = 0; r < 6; r++) round($urandom_range(1, 15));

        // R3 size change while running is ignored
        reg_write(2'd3, 32'h0002_0000, 4'b0100);
        reg_read(2'd3, d); check("R3 size frozen while running", {62'h0, d[17:16]}, 64'h1);

        // R6 stop while a command is in flight
        hold_ready = 1'b1;
        push(1);
        begin
            int t = 0;
            while (!cmd_valid && t < 100) begin @(negedge clk); t++; end
        end
        reg_write(2'd3, 32'h0, 4'b0001);
        repeat (3) @(negedge clk);
        reg_read(2'd3, d); check("R6 run bit stays 1 while busy", {63'h0, d[1]}, 64'h1);
        hold_ready = 1'b0;
        wait_drain();
        reg_read(2'd3, d); check("R6 run bit 0 once idle", {63'h0, d[1]}, 64'h0);
        f0 = n_fetch;
        push(2);
        repeat (20) @(negedge clk);
        check("R6 no fetch after stop", {32'h0, n_fetch}, {32'h0, f0});
        reg_write(2'd3, 32'h2, 4'b0001);
        wait_drain();
        stop_engine();

        // R7 pointer reset, R10 write pointer upper byte
        ptr_reset();
        reg_write(2'd2, 32'h0000_1234, 4'b0011);
        reg_read(2'd2, d); check("R10 write pointer upper byte ignored", {48'h0, d[15:0]}, 64'h0034);
        reg_write(2'd2, 32'h0, 4'b0011);

        // 256-entry ring with a nonzero upper base
        set_size(2'b10);
        exp_hi = 32'h0000_0001;
        reg_write(2'd1, exp_hi, 4'b1111);
        reg_write(2'd3, 32'h2, 4'b0001);
        round(255);
        for (int r = 0; r < 3; r++) round($urandom_range(1, 255));
        stop_engine();

        // 2-entry ring
        ptr_reset();
        set_size(2'b00);
        reg_write(2'd3, 32'h2, 4'b0001);
        for (int r = 0; r < 5; r++) round(1);
        stop_engine();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule